// File: doc/BRIEF.md
# Adaptive Binary Arithmetic Encoder

This block compresses a serial stream of bits. Each accepted bit is coded against an adaptive order-0 model. The model keeps one occurrence count per bit value, and both counts start equal at the beginning of every message. The current probability of a zero and of a one, both in 16-bit fixed point, is always visible on two outputs. An interval coder holds a fixed-point pair `low`/`high`. For each bit it keeps the sub-interval that belongs to that bit: zero takes the lower share, whose size follows the zero count, and one takes the rest. The decoder can rebuild the same counts from the decoded bits, so no table is sent.

Bits arrive over a valid/ready stream. The block takes one bit, then drops `in_ready` while a shared bit-serial divider works out the split point and then the refreshed probability. Back-pressure rules are as follows. A bit is consumed only on a cycle where `in_valid` and `in_ready` are both high. `in_bit` and `in_last` are sampled only on that cycle. While `in_ready` is low, the producer may hold or change its data freely.

A message ends on a bit accepted with `in_last` set, or on its eighth bit. The encoder then places the midpoint of the final interval on `tag`. It pulses `tag_valid` and `dec_start` together for one cycle and restarts model and interval for the next message. Fixed point uses 0xFFFF as 1.0.

Top module: `ac_bin_encoder`

## Requirements
- R1: A bit is taken only on a clock where `in_valid` and `in_ready` are both high; `in_ready` is low from the clock after an acceptance until the bit is fully processed, and inputs offered while it is low have no effect on `prob0`, `prob1` or `tag`.
- R2: After reset `in_ready`=1, `tag_valid`=0, `dec_start`=0, `tag`=0, `prob0`=0x7FFF and `prob1`=0x8000.
- R3: When `in_ready` returns high after a non-final bit, `prob0` = floor(0xFFFF·c0/(c0+c1)) and `prob1` = 0xFFFF − `prob0`, using the counts after that bit.
- R4: Both counts start at 1 for each message; an accepted 0 adds one to c0 and an accepted 1 adds one to c1.
- R5: When an increment brings either count to CNT_MAX (default 255), both counts are halved with rounding up, c ← (c+1)/2, so neither falls to zero.
- R6: Each message starts with low=0 and high=0xFFFF. With span = high − low and off = floor(span·c0/(c0+c1)) from the counts before the bit: a 0 sets high = low + off, and a 1 sets low = low + off.
- R7: A message ends on a bit accepted with `in_last`=1, or on its MAX_BITS-th (default 8) accepted bit, whichever comes first.
- R8: At the end of a message `tag` = low + floor((high − low)/2) of the final interval. It is held until the next message ends.
- R9: `tag_valid` and `dec_start` are high together for exactly one cycle, the first cycle in which `in_ready` is high again after the final bit.
- R10: After a message ends, counts, interval and probability outputs return to their start values, so a repeated message yields the same tag.
- R11: The interval stays non-empty: low < high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Encoder can take a bit this cycle |
| in_bit | input | 1 | Data bit to code |
| in_last | input | 1 | Offered bit closes the message |
| prob0 | output | 16 | Current probability of a 0 (0xFFFF = 1.0) |
| prob1 | output | 16 | Current probability of a 1 |
| tag | output | 16 | Code value of the last finished message |
| tag_valid | output | 1 | One-cycle strobe: `tag` is new |
| dec_start | output | 1 | One-cycle pulse telling the decoder to begin |

## Verification
Some properties are checked on every cycle by the assertions. These are: the interval stays non-empty; a coded zero leaves `low` untouched and a coded one leaves `high` untouched; counts stay in 1..CNT_MAX−1 and move only on a coded bit; each divider result is a true floor quotient; `in_ready` never coincides with a busy divider; the end strobe lasts one cycle; and the length limit forces a message end. Other behaviour only the directed scenarios can show, because it needs an independent arithmetic model of the whole message. This covers the exact probability values after each bit, the exact tag for mixed, all-zero and maximum-length messages, count halving, and the restart between messages. It also covers the fact that bits offered while the block is busy leave no trace.

// File: rtl/ac_enc_pkg.sv
package ac_enc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_PSTART,
    ST_PROB,
    ST_DONE
  } enc_state_t;
endpackage

// File: rtl/ac_seq_div.sv
// Restoring bit-serial divider: one quotient bit per clock.
module ac_seq_div #(
  parameter int NW = 24,
  parameter int DW = 9,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quot
);
  localparam int CNTW = $clog2(NW + 1);
  localparam int WW   = NW + DW + 1;

  logic [CNTW-1:0] cnt_q;
  logic [DW-1:0]   rem_q;
  logic [NW-1:0]   q_q;
  logic [NW-1:0]   num_q;
  logic [DW-1:0]   den_q;
  logic            done_q;
  logic [DW:0]     trial;
  logic [DW:0]     diff;
  logic            fits;

  always_comb begin
    trial = {rem_q, q_q[NW-1]};
    diff  = trial - {1'b0, den_q};
    fits  = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      num_q  <= '0;
      den_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        cnt_q <= CNTW'(NW);
        rem_q <= '0;
        q_q   <= num;
        num_q <= num;
        den_q <= den;
      end else if (cnt_q != '0) begin
        rem_q  <= fits ? diff[DW-1:0] : trial[DW-1:0];
        q_q    <= {q_q[NW-2:0], fits};
        cnt_q  <= cnt_q - 1'b1;
        done_q <= (cnt_q == CNTW'(1));
      end
    end
  end

  assign busy = (cnt_q != '0);
  assign done = done_q;
  assign quot = q_q[QW-1:0];

  logic [WW-1:0] q_w, n_w, d_w;
  always_comb begin
    q_w = WW'(q_q);
    n_w = WW'(num_q);
    d_w = WW'(den_q);
  end

  // R3
  div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((q_w * d_w <= n_w) && (n_w < (q_w + 1) * d_w)));

  // R6
  div_den_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (den != '0));
endmodule

// File: rtl/ac_bit_model.sv
// Adaptive order-0 model: two bit counts and the published probabilities.
module ac_bit_model #(
  parameter int PW      = 16,
  parameter int CNT_MAX = 255,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic          bit_in,
  input  logic          prob_load,
  input  logic [PW-1:0] prob_val,
  output logic [CW-1:0] c0,
  output logic [CW:0]   tot,
  output logic [PW-1:0] prob0,
  output logic [PW-1:0] prob1
);
  localparam logic [PW-1:0] ONE     = '1;
  localparam logic [PW-1:0] P0_INIT = ONE >> 1;
  localparam logic [CW:0]   SAT     = (CW+1)'(CNT_MAX);

  logic [CW-1:0] c0_q, c1_q;
  logic [PW-1:0] p0_q, p1_q;
  logic [CW:0]   w0, w1, n0, n1;
  logic          sat;

  always_comb begin
    w0  = {1'b0, c0_q} + (CW+1)'(!bit_in);
    w1  = {1'b0, c1_q} + (CW+1)'(bit_in);
    sat = (w0 == SAT) || (w1 == SAT);
    n0  = sat ? ((w0 + 1'b1) >> 1) : w0;
    n1  = sat ? ((w1 + 1'b1) >> 1) : w1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= CW'(1);
      c1_q <= CW'(1);
      p0_q <= P0_INIT;
      p1_q <= ONE - P0_INIT;
    end else if (clr) begin
      c0_q <= CW'(1);
      c1_q <= CW'(1);
      p0_q <= P0_INIT;
      p1_q <= ONE - P0_INIT;
    end else begin
      if (upd) begin
        c0_q <= n0[CW-1:0];
        c1_q <= n1[CW-1:0];
      end
      if (prob_load) begin
        p0_q <= prob_val;
        p1_q <= ONE - prob_val;
      end
    end
  end

  assign c0    = c0_q;
  assign tot   = {1'b0, c0_q} + {1'b0, c1_q};
  assign prob0 = p0_q;
  assign prob1 = p1_q;

  // R5
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_q >= CW'(1)) && (c1_q >= CW'(1)) &&
    ({1'b0, c0_q} < SAT) && ({1'b0, c1_q} < SAT));

  // R4
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> ($stable(c0_q) && $stable(c1_q)));
endmodule

// File: rtl/ac_range_coder.sv
// Fixed-point interval [low, high] and the tag register.
module ac_range_coder #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic          bit_in,
  input  logic [PW-1:0] off,
  input  logic          tag_load,
  output logic [PW-1:0] span,
  output logic [PW-1:0] tag
);
  localparam logic [PW-1:0] ONE = '1;

  logic [PW-1:0] low_q, high_q, tag_q, mid;

  always_comb begin
    span = high_q - low_q;
    mid  = low_q + (span >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= ONE;
      tag_q  <= '0;
    end else begin
      if (tag_load) tag_q <= mid;
      if (clr) begin
        low_q  <= '0;
        high_q <= ONE;
      end else if (upd) begin
        if (bit_in) low_q  <= low_q + off;
        else        high_q <= low_q + off;
      end
    end
  end

  assign tag = tag_q;

  // R11
  low_lt_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_q < high_q);

  // R6
  zero_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && !bit_in) |=> $stable(low_q));

  // R6
  one_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && bit_in) |=> $stable(high_q));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((low_q == '0) && (high_q == ONE)));
endmodule

// File: rtl/ac_bin_encoder.sv
module ac_bin_encoder #(
  parameter int PW       = 16,
  parameter int CNT_MAX  = 255,
  parameter int MAX_BITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  input  logic          in_last,
  output logic [PW-1:0] prob0,
  output logic [PW-1:0] prob1,
  output logic [PW-1:0] tag,
  output logic          tag_valid,
  output logic          dec_start
);
  import ac_enc_pkg::*;

  localparam int CW  = $clog2(CNT_MAX + 1);
  localparam int DW  = CW + 1;
  localparam int NW  = PW + CW;
  localparam int BCW = $clog2(MAX_BITS + 1);
  localparam logic [PW-1:0] ONE = '1;

  enc_state_t     state_q;
  logic           bit_q, last_q, tv_q;
  logic [BCW-1:0] bcnt_q;
  logic           accept, at_limit;
  logic           div_start, div_busy, div_done;
  logic [NW-1:0]  div_num;
  logic [PW-1:0]  div_quot, factor, span;
  logic [CW-1:0]  c0;
  logic [CW:0]    tot;
  logic           split_done, prob_done, finish;

  always_comb begin
    in_ready   = (state_q == ST_IDLE);
    accept     = in_valid && in_ready;
    at_limit   = (bcnt_q == BCW'(MAX_BITS - 1));
    factor     = (state_q == ST_PSTART) ? ONE : span;
    div_num    = NW'(factor) * NW'(c0);
    div_start  = accept || (state_q == ST_PSTART);
    split_done = (state_q == ST_SPLIT) && div_done;
    prob_done  = (state_q == ST_PROB) && div_done;
    finish     = (state_q == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= 1'b0;
      last_q  <= 1'b0;
      bcnt_q  <= '0;
      tv_q    <= 1'b0;
    end else begin
      tv_q <= finish;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          bit_q   <= in_bit;
          last_q  <= in_last || at_limit;
          bcnt_q  <= bcnt_q + 1'b1;
          state_q <= ST_SPLIT;
        end
        ST_SPLIT:  if (div_done) state_q <= last_q ? ST_DONE : ST_PSTART;
        ST_PSTART: state_q <= ST_PROB;
        ST_PROB:   if (div_done) state_q <= ST_IDLE;
        ST_DONE: begin
          bcnt_q  <= '0;
          state_q <= ST_IDLE;
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  ac_seq_div #(.NW(NW), .DW(DW), .QW(PW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (tot),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  ac_bit_model #(.PW(PW), .CNT_MAX(CNT_MAX), .CW(CW)) u_model (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (finish),
    .upd       (split_done),
    .bit_in    (bit_q),
    .prob_load (prob_done),
    .prob_val  (div_quot),
    .c0        (c0),
    .tot       (tot),
    .prob0     (prob0),
    .prob1     (prob1)
  );

  ac_range_coder #(.PW(PW)) u_coder (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (finish),
    .upd      (split_done),
    .bit_in   (bit_q),
    .off      (div_quot),
    .tag_load (finish),
    .span     (span),
    .tag      (tag)
  );

  assign tag_valid = tv_q;
  assign dec_start = tv_q;

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !div_busy);

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R9
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |=> !tag_valid);

  // R9
  trig_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> in_ready);

  // R7
  max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && at_limit) |=> last_q);
endmodule

// File: tb/tb_ac_bin_encoder.sv
module tb_ac_bin_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int P_CNT      = 6;
  localparam int P_MAX      = 8;
  localparam int ONE        = 65535;
  localparam int WDOG       = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
  logic in_ready, tag_valid, dec_start;
  logic [15:0] prob0, prob1, tag;

  int checks = 0;
  int errors = 0;
  int m_c0, m_c1, m_low, m_high, m_n;
  bit noise = 1'b0;

  ac_bin_encoder #(.PW(16), .CNT_MAX(P_CNT), .MAX_BITS(P_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_last(in_last), .prob0(prob0), .prob1(prob1),
    .tag(tag), .tag_valid(tag_valid), .dec_start(dec_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_c0 = 1; m_c1 = 1; m_low = 0; m_high = ONE; m_n = 0;
  endtask

  task automatic model_step(input bit b);
    int span, off, w0, w1;
    span = m_high - m_low;
    off  = (span * m_c0) / (m_c0 + m_c1);
    if (b) m_low = m_low + off;
    else   m_high = m_low + off;
    w0 = m_c0 + (b ? 0 : 1);
    w1 = m_c1 + (b ? 1 : 0);
    if (w0 == P_CNT || w1 == P_CNT) begin
      w0 = (w0 + 1) / 2;
      w1 = (w1 + 1) / 2;
    end
    m_c0 = w0; m_c1 = w1; m_n++;
  endtask

  // Offers one bit, waits for its result and checks it. Returns the tag at message end.
  task automatic send_bit(input bit b, input bit last, output int tag_out);
    int exp_p0, exp_tag;
    bit ends;
    tag_out = -1;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_last = last;
    @(negedge clk);
    check(in_ready == 1'b0, "R1 ready low after accept", int'(in_ready), 0);
    if (noise) begin
      in_valid = 1'b1; in_bit = ~b; in_last = 1'b1;
    end else begin
      in_valid = 1'b0;
    end
    model_step(b);
    ends = last || (m_n == P_MAX);
    if (ends) begin
      while (!tag_valid) @(negedge clk);
      exp_tag = m_low + (m_high - m_low) / 2;
      check(int'(tag) == exp_tag, "R6/R8/R11 tag", int'(tag), exp_tag);
      check(dec_start && in_ready, "R9 trigger with tag_valid", int'(dec_start), 1);
      tag_out = int'(tag);
      @(negedge clk);
      check(!tag_valid && !dec_start, "R9 one-cycle pulse", int'(tag_valid), 0);
      check(int'(prob0) == 32767 && int'(prob1) == 32768, "R10 probs restart",
            int'(prob0), 32767);
      check(int'(tag) == exp_tag, "R8 tag held", int'(tag), exp_tag);
      model_reset();
    end else begin
      while (!in_ready) @(negedge clk);
      exp_p0 = (ONE * m_c0) / (m_c0 + m_c1);
      check(int'(prob0) == exp_p0, "R3/R4 prob0", int'(prob0), exp_p0);
      check(int'(prob1) == ONE - exp_p0, "R3 prob1", int'(prob1), ONE - exp_p0);
    end
  endtask

  task automatic send_msg(input logic [7:0] bits, input int n, input bit use_last,
                          output int tag_out);
    int t;
    tag_out = -1;
    for (int i = 0; i < n; i++) begin
      send_bit(bits[i], use_last && (i == n - 1), t);
      if (t >= 0) tag_out = t;
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R2 in_ready", int'(in_ready), 1);
    check(!tag_valid && !dec_start, "R2 strobes low", int'(tag_valid), 0);
    check(tag == 16'd0, "R2 tag", int'(tag), 0);
    check(prob0 == 16'h7FFF, "R2 prob0", int'(prob0), 32767);
    check(prob1 == 16'h8000, "R2 prob1", int'(prob1), 32768);
  endtask

  task automatic t_single_zero();
    int t;
    send_msg(8'b0000_0000, 1, 1'b1, t);
    check(t == 16383, "R6 single zero tag", t, 16383);
  endtask

  task automatic t_mixed();
    int t;
    send_msg(8'b0001_1010, 5, 1'b1, t);
    check(t >= 0, "R7 in_last ends message", t, 0);
  endtask

  task automatic t_max_len();
    int t;
    send_msg(8'b1011_0110, 8, 1'b0, t);
    check(t >= 0, "R7 length limit ends message", t, 0);
  endtask

  task automatic t_halving();
    int t;
    send_bit(1'b0, 1'b0, t);
    send_bit(1'b0, 1'b0, t);
    send_bit(1'b0, 1'b0, t);
    send_bit(1'b0, 1'b0, t);
    send_bit(1'b0, 1'b0, t);
    check(int'(prob0) == 49151, "R5 halved counts 3:1", int'(prob0), 49151);
    send_bit(1'b1, 1'b1, t);
    in_valid = 1'b0;
  endtask

  task automatic t_backpressure();
    int t;
    noise = 1'b1;
    send_msg(8'b0000_0110, 4, 1'b1, t);
    noise = 1'b0;
    check(t >= 0, "R1 busy-time inputs ignored", t, 0);
  endtask

  task automatic t_restart();
    int t1, t2;
    send_msg(8'b0010_1101, 6, 1'b1, t1);
    send_msg(8'b0010_1101, 6, 1'b1, t2);
    check(t1 == t2, "R10 repeat message same tag", t2, t1);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_zero();
    t_mixed();
    t_max_len();
    t_halving();
    t_backpressure();
    t_restart();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule